// File: doc/BRIEF.md
# Three-Channel Command Mailbox Responder

This block is the responder side of a memory-mapped command mailbox. A host sees three channels, each a 16-byte window holding a low data word, an interface word and a high data word. The host loads the data words, then writes the interface word with the run flag set, a command code and two 8-bit parameters. The block hands the command to a built-in behavioural executor. That executor takes a fixed, parameterised number of cycles, writes result data back, places an error code where the command code was, clears the run flag and raises a one-cycle interrupt.

Channel 0 serves firmware-class requests and carries a 32-bit payload. Channels 1 (graphics class) and 2 (imaging class) carry 64-bit payloads across the low and high words. The executor models only two behaviours. A command code above `MAX_CMD` is rejected as invalid and its data is left as it was. Any other code succeeds and returns both payload words bit-inverted. Each channel has a pending bit, readable in the interface word, that tells which channel raised the interrupt. Reading the interface word clears it.

Top module: `mbx_regfile`

## Requirements
- R1: Register map: channel c (0, 1, 2) occupies byte addresses 0x10*c to 0x10*c+0xF, with the low data word at +0x0, the interface word at +0x4 and the high data word at +0x8; address bits 1:0 are ignored. A read of +0xC in any channel, or of any address at or above 0x30, returns zero.
- R2: Interface word fields: bit 31 run flag, bit 30 pending flag (read only), bits 29:24 read as zero, bits 23:16 parameter 2, bits 15:8 parameter 1, bits 7:0 command code when written and error code after completion.
- R3: A write to the interface word of an idle channel with bit 31 clear stores bits 23:0 and starts nothing: no interrupt follows and the word reads back with run clear.
- R4: A write to the interface word of an idle channel with bit 31 set starts a command. The run flag reads 1 until completion, and completion happens exactly `EXEC_CYCLES` clock edges after the edge that captured the write.
- R5: On completion, the run flag is cleared, bits 7:0 hold the error code and both parameter fields keep their written values.
- R6: Error codes: 0 success, 1 invalid command, 2 invalid parameter, 3 timeout, 4 locked, 5 invalid regulator ID, 6 regulator fault. The executor returns 1 for a command code greater than `MAX_CMD` (default 0x1B) and leaves the data words unchanged; for any other code it returns 0 and inverts every bit of the channel's data words.
- R7: Channel 0 has no high data word: a read of address 0x08 returns zero and a write to it is dropped. On channels 1 and 2 both data words take part in the result.
- R8: `irq` is high for exactly one cycle, the cycle right after the completion edge, which is the same cycle in which the run flag first reads 0. Completions on several channels at one edge give one pulse.
- R9: A channel's pending flag is set by its completion and cleared by a read of that channel's interface word. That read returns the flag as it was before the clear. If a completion and the read fall on the same edge, the flag stays set.
- R10: While a channel's run flag is set, writes to its interface, low data and high data words are ignored.
- R11: `rdata` is registered. It takes the addressed value at the edge that samples `rd_en` and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W (8) | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
Every result has a fixed due cycle. Read data appears one edge after the read strobe. Completion falls exactly `EXEC_CYCLES` edges after the start write, and `irq` and the cleared run flag are visible in the cycle after that. The bench drives and samples only on falling edges. It measures latency by counting falling edges from the start write to the first high `irq`, so an early or late completion is caught by its count. It confirms the pulse has ended one cycle later, and reads the interface word only after the pulse, when its contents are settled.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef enum logic [7:0] {
    MBX_OK         = 8'd0,
    MBX_BAD_CMD    = 8'd1,
    MBX_BAD_PARAM  = 8'd2,
    MBX_TIMEOUT    = 8'd3,
    MBX_LOCKED     = 8'd4,
    MBX_BAD_RAIL   = 8'd5,
    MBX_RAIL_FAULT = 8'd6
  } mbx_err_e;

  typedef enum logic [1:0] {
    REG_LO  = 2'd0,
    REG_IF  = 2'd1,
    REG_HI  = 2'd2,
    REG_GAP = 2'd3
  } mbx_reg_e;

  localparam int RUN_BIT  = 31;
  localparam int PEND_BIT = 30;

  // Behavioural executor verdict for a command code.
  function automatic mbx_err_e exec_status(input logic [7:0] cmd, input logic [7:0] max_cmd);
    return (cmd > max_cmd) ? MBX_BAD_CMD : MBX_OK;
  endfunction

  // Result payload: inverted on success, untouched on failure.
  function automatic logic [31:0] exec_payload(input logic [31:0] d, input logic ok);
    return ok ? ~d : d;
  endfunction

  // Stored image of a host write to the interface word.
  function automatic logic [31:0] if_store(input logic [31:0] w);
    return {w[31], 7'b0, w[23:0]};
  endfunction

  // Host view of the interface word with the pending flag merged in.
  function automatic logic [31:0] if_readback(input logic [31:0] ifr, input logic pend);
    return {ifr[31], pend, 6'b0, ifr[23:0]};
  endfunction

endpackage

// File: rtl/mbx_timer.sv
module mbx_timer #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic busy,
  output logic fin
);
  localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt <= '0;
    else if (start)               cnt <= CW'(CYCLES - 1);
    else if (busy && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign fin = busy && (cnt == '0);
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel
  import mbx_pkg::*;
#(
  parameter bit         WIDE        = 1'b1,
  parameter int         EXEC_CYCLES = 4,
  parameter logic [7:0] MAX_CMD     = 8'h1B
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_lo,
  input  logic        wr_if,
  input  logic        wr_hi,
  input  logic        rd_if,
  input  logic [31:0] wdata,
  output logic [31:0] lo_q,
  output logic [31:0] if_q,
  output logic [31:0] hi_q,
  output logic        run,
  output logic        pend,
  output logic        fin
);
  logic [31:0] lo_r, ifr;
  logic        pend_r, start, ok;
  mbx_err_e    err;

  assign run   = ifr[RUN_BIT];
  assign start = wr_if && !run && wdata[RUN_BIT];
  assign err   = exec_status(ifr[7:0], MAX_CMD);
  assign ok    = (err == MBX_OK);

  mbx_timer #(.CYCLES(EXEC_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(run), .fin(fin)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_r   <= '0;
      ifr    <= '0;
      pend_r <= 1'b0;
    end else begin
      if (fin)                lo_r <= exec_payload(lo_r, ok);
      else if (wr_lo && !run) lo_r <= wdata;

      if (fin)                ifr <= {1'b0, ifr[30:8], 8'(err)};
      else if (wr_if && !run) ifr <= if_store(wdata);

      if (fin)                pend_r <= 1'b1;
      else if (rd_if)         pend_r <= 1'b0;
    end
  end

  generate
    if (WIDE) begin : g_wide
      logic [31:0] hi_r;
      always_ff @(posedge clk) begin
        if (!rst_n)             hi_r <= '0;
        else if (fin)           hi_r <= exec_payload(hi_r, ok);
        else if (wr_hi && !run) hi_r <= wdata;
      end
      assign hi_q = hi_r;
    end else begin : g_narrow
      logic unused_hi;
      assign unused_hi = wr_hi;
      assign hi_q = '0;
    end
  endgenerate

  assign lo_q = lo_r;
  assign pend = pend_r;
  assign if_q = if_readback(ifr, pend_r);
endmodule

// File: rtl/mbx_regfile.sv
module mbx_regfile
  import mbx_pkg::*;
#(
  parameter int         ADDR_W      = 8,
  parameter int         EXEC_CYCLES = 4,
  parameter logic [7:0] MAX_CMD     = 8'h1B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq
);
  localparam int NUM_CH   = 3;
  localparam int CH_IDX_W = ADDR_W - 4;

  logic [CH_IDX_W-1:0] ch_sel;
  mbx_reg_e            reg_sel;
  logic                in_map;
  logic [1:0]          unused_lsb;

  assign ch_sel     = addr[ADDR_W-1:4];
  assign reg_sel    = mbx_reg_e'(addr[3:2]);
  assign in_map     = ch_sel < CH_IDX_W'(NUM_CH);
  assign unused_lsb = addr[1:0];

  logic [31:0]       lo_v [NUM_CH];
  logic [31:0]       if_v [NUM_CH];
  logic [31:0]       hi_v [NUM_CH];
  logic [NUM_CH-1:0] fin_v, run_v, pend_v;

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic hit;
      assign hit = in_map && (ch_sel == CH_IDX_W'(i));
      mbx_channel #(
        .WIDE(i != 0), .EXEC_CYCLES(EXEC_CYCLES), .MAX_CMD(MAX_CMD)
      ) u_ch (
        .clk(clk), .rst_n(rst_n),
        .wr_lo(wr_en && hit && reg_sel == REG_LO),
        .wr_if(wr_en && hit && reg_sel == REG_IF),
        .wr_hi(wr_en && hit && reg_sel == REG_HI),
        .rd_if(rd_en && hit && reg_sel == REG_IF),
        .wdata(wdata),
        .lo_q(lo_v[i]), .if_q(if_v[i]), .hi_q(hi_v[i]),
        .run(run_v[i]), .pend(pend_v[i]), .fin(fin_v[i])
      );
    end
  endgenerate

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (in_map && ch_sel == CH_IDX_W'(i)) begin
        case (reg_sel)
          REG_LO:  rd_mux = lo_v[i];
          REG_IF:  rd_mux = if_v[i];
          REG_HI:  rd_mux = hi_v[i];
          default: rd_mux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      if (rd_en) rdata <= rd_mux;
      irq <= |fin_v;
    end
  end
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
  parameter int ADDR_W      = 8,
  parameter int EXEC_CYCLES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       rdata,
  input logic              irq,
  input logic [2:0]        fin_v,
  input logic [2:0]        run_v,
  input logic [2:0]        pend_v
);
  AST_IRQ_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (|fin_v) |=> irq);                                              // R8

  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr[ADDR_W-1:4] >= 3) |=> (rdata == 32'd0));         // R1

  AST_GAP_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr[3:2] == 2'd3) |=> (rdata == 32'd0));             // R1

  generate
    for (genvar i = 0; i < 3; i++) begin : g_chk
      int age;
      always_ff @(posedge clk) begin
        if (!rst_n || !run_v[i]) age <= 1;
        else                     age <= age + 1;
      end

      AST_DONE_CLEARS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        fin_v[i] |=> !run_v[i]);                                    // R5

      AST_RUN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (run_v[i] && !fin_v[i]) |=> run_v[i]);                      // R4

      AST_EXACT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        fin_v[i] |-> (age == EXEC_CYCLES));                         // R4

      AST_DONE_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        fin_v[i] |=> pend_v[i]);                                    // R9

      AST_READ_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr[ADDR_W-1:4] == (ADDR_W-4)'(i) && addr[3:2] == 2'd1 && !fin_v[i])
        |=> !pend_v[i]);                                            // R9
    end
  endgenerate
endmodule

bind mbx_regfile mbx_checker #(.ADDR_W(ADDR_W), .EXEC_CYCLES(EXEC_CYCLES)) u_mbx_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .rdata(rdata),
  .irq(irq), .fin_v(fin_v), .run_v(run_v), .pend_v(pend_v)
);

// File: tb/tb_mbx_regfile.sv
module tb_mbx_regfile;
  localparam int         LAT  = 4;
  localparam logic [7:0] MAXC = 8'h1B;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          n_tests = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  mbx_regfile #(.ADDR_W(8), .EXEC_CYCLES(LAT), .MAX_CMD(MAXC)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Both tasks are entered on a falling edge and return on one.
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0; d = rdata;
  endtask

  // Falling edges from the start write until irq is seen.
  task automatic wait_irq(output int c);
    c = 0;
    while (!irq && c < 40) begin
      @(negedge clk); c++;
    end
  endtask

  function automatic logic [7:0] pick_cmd(input int k);
    case (k)
      0: return 8'h00;
      1: return 8'h05;
      2: return MAXC;
      3: return MAXC + 8'd1;
      default: return 8'hFF;
    endcase
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    chk("R8 irq after reset", {31'b0, irq}, 32'd0);
    for (int a = 0; a < 12; a++) begin
      rd(8'(a * 4), v);
      chk("R1 reset value", v, 32'd0);
    end

    // R1 holes and R7 narrow channel high word
    wr(8'h00, 32'hDEAD_BEEF);
    wr(8'h08, 32'h1111_2222);
    wr(8'h0C, 32'h3333_4444);
    rd(8'h0C, v); chk("R1 gap word", v, 32'd0);
    rd(8'h30, v); chk("R1 past windows", v, 32'd0);
    rd(8'hFC, v); chk("R1 top address", v, 32'd0);
    rd(8'h08, v); chk("R7 ch0 high word", v, 32'd0);
    rd(8'h00, v); chk("R1 ch0 low word", v, 32'hDEAD_BEEF);
    rd(8'h03, v); chk("R11 rdata holds ignoring lsb", v, 32'hDEAD_BEEF);
    @(negedge clk);
    chk("R11 rdata held", rdata, 32'hDEAD_BEEF);

    // R3 store without start
    wr(8'h14, 32'h7F12_3405);
    c = 0;
    for (int k = 0; k < LAT + 3; k++) begin
      @(negedge clk); if (irq) c++;
    end
    chk("R3 no irq without run", 32'(c), 32'd0);
    rd(8'h14, v); chk("R3 R2 stored fields", v, 32'h0012_3405);

    // Sweep over channels and command codes
    for (int ch = 0; ch < 3; ch++) begin
      for (int k = 0; k < 5; k++) begin
        logic [7:0]  cmd, p1, p2;
        logic [31:0] lo, hi, elo, ehi, eif;
        logic        good;
        cmd = pick_cmd(k);
        p1  = cmd ^ 8'h5A;
        p2  = 8'(ch) + 8'h10;
        lo  = 32'h1234_0000 + 32'(ch * 256) + 32'(cmd);
        hi  = 32'hF0F0_0000 ^ {16'd0, cmd, 8'(ch)};
        good = (cmd <= MAXC);
        elo = good ? ~lo : lo;
        ehi = (ch == 0) ? 32'd0 : (good ? ~hi : hi);
        eif = {1'b0, 1'b1, 6'b0, p2, p1, good ? 8'd0 : 8'd1};
        wr(8'(ch * 16 + 0), lo);
        wr(8'(ch * 16 + 8), hi);
        wr(8'(ch * 16 + 4), {1'b1, 7'b0, p2, p1, cmd});
        wait_irq(c);
        chk("R4 completion latency", 32'(c), 32'(LAT));
        @(negedge clk);
        chk("R8 irq one cycle", {31'b0, irq}, 32'd0);
        rd(8'(ch * 16 + 4), v); chk("R5 R6 R9 completed interface", v, eif);
        rd(8'(ch * 16 + 4), v); chk("R9 pending cleared", v, eif & ~32'h4000_0000);
        rd(8'(ch * 16 + 0), v); chk("R6 low result", v, elo);
        rd(8'(ch * 16 + 8), v); chk("R7 R6 high result", v, ehi);
      end
    end

    // R10 writes while running are dropped; run reads 1 meanwhile
    wr(8'h10, 32'h0000_FFFF);
    wr(8'h18, 32'hAAAA_0000);
    wr(8'h14, 32'h8022_3303);
    rd(8'h14, v); chk("R4 run flag while busy", v, 32'h8022_3303);
    wr(8'h14, 32'h80FF_FF00);
    wr(8'h10, 32'h5555_5555);
    wait_irq(c);
    chk("R10 latency unchanged", 32'(c), 32'(LAT - 3));
    @(negedge clk);
    rd(8'h14, v); chk("R10 interface write ignored", v, 32'h4022_3300);
    rd(8'h10, v); chk("R10 low write ignored", v, 32'hFFFF_0000);
    rd(8'h18, v); chk("R10 high result", v, 32'h5555_FFFF);

    // Two channels completing on adjacent edges
    wr(8'h24, 32'h8000_0001);
    wr(8'h04, 32'h8000_0002);
    c = 0;
    for (int k = 0; k < LAT + 4; k++) begin
      @(negedge clk); if (irq) c++;
    end
    chk("R8 one pulse per completion", 32'(c), 32'd2);
    rd(8'h24, v); chk("R9 ch2 pending", v & 32'h4000_0000, 32'h4000_0000);
    rd(8'h04, v); chk("R9 ch0 pending", v & 32'h4000_0000, 32'h4000_0000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule